// File: doc/BRIEF.md
# Integer Fixed-Point PID Controller

This block is a sampled, discrete proportional-integral-derivative controller that works entirely in integer arithmetic. A pulse on the sample strobe captures a signed setpoint, a signed process measurement and three unsigned fixed-point gains. One clock later the block presents a single control value, clamped to a programmable window, together with a one-cycle valid pulse. The gains arrive already scaled. Converting time constants into gains is left to whatever programs the block.

The integral path adds the gain-weighted error to a stored sum on every sample, rather than scaling a stored error sum. Gains can therefore be retuned while the loop runs without a jump at the output. The stored sum is held inside the scaled output window, so it cannot wind up while the output sits at a limit. The derivative path works on the sample-to-sample change of the measurement, so a setpoint step produces no derivative kick. Every intermediate value is computed wide enough, or clamped, so that nothing wraps. Every removal of the fractional scale is an arithmetic right shift, which rounds toward negative infinity.

Top module: `fxp_pid`

## Requirements
- R1: Each gain is an unsigned 16-bit value with 8 fractional bits (value = code / 256). The control value is floor((Kp·e + I − Kd·d) / 256), clamped to the window, where I is the updated integral sum and d is the measurement change.
- R2: The error is e = setpoint − measurement, evaluated exactly over the full signed input range.
- R3: The derivative term uses d = measurement(n) − measurement(n−1). A setpoint change with a steady measurement contributes no derivative action.
- R4: A sample taken with the initialize input high starts from an integral sum of zero and uses d = 0. The new measurement becomes the stored previous value.
- R5: The first sample after reset behaves as if the initialize input were high.
- R6: The control value always lies within [low limit, high limit] of the sample that produced it.
- R7: After each sample the integral sum is clamped to [low·256, high·256]. A long saturation therefore does not delay recovery once the error reverses.
- R8: The integral sum accumulates Ki·e every sample. Changing any gain while the error is zero and the measurement is steady leaves the control value unchanged.
- R9: Removing the 2^8 scale rounds toward negative infinity. For example, a product of −128 yields −1.
- R10: The control value and a one-cycle valid pulse appear on the clock edge after a strobed cycle. Between strobes the valid output is low and the control value is held.
- R11: After reset the control value is 0 and valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe; one computation per strobed cycle |
| init_req | input | 1 | Restart integral and derivative state on this sample |
| sp | input | 16 | Signed setpoint |
| pv | input | 16 | Signed process measurement |
| kp_g | input | 16 | Proportional gain, unsigned 8.8 |
| ki_g | input | 16 | Integral gain per sample, unsigned 8.8 |
| kd_g | input | 16 | Derivative gain per sample, unsigned 8.8 |
| lim_hi | input | 16 | Signed upper output limit |
| lim_lo | input | 16 | Signed lower output limit (must not exceed lim_hi) |
| u_out | output | 16 | Signed control value |
| u_vld | output | 1 | One-cycle pulse marking a new control value |

## Verification
A corrupted integral sum shows up at the port on the very next sample. The output then differs from the value computed from the error history, and the difference persists until an initialize or a clamp absorbs it. A stale previous-measurement register shows up as a derivative offset on the next strobe. A wrong first-sample flag shows up as a derivative kick on the first sample after reset. The sweeps compare every sample against an arithmetic model, so any such fault is caught within one sample of the sample that caused it.

// File: rtl/pid_pkg.sv
package pid_pkg;
   typedef enum int {
      G_PROP  = 0,
      G_INTEG = 1,
      G_DERIV = 2
   } gain_idx_e;
   localparam int N_GAIN = 3;
endpackage

// File: rtl/pid_gmul.sv
module pid_gmul #(
   parameter int AW = 17,
   parameter int GW = 16,
   localparam int PW = AW + GW + 1
) (
   input  logic signed [AW-1:0] opnd,
   input  logic        [GW-1:0] gain,
   output logic signed [PW-1:0] prod
);
   logic signed [GW:0] gain_s;
   assign gain_s = $signed({1'b0, gain});
   assign prod   = PW'(opnd) * PW'(gain_s);
endmodule

// File: rtl/pid_sat.sv
module pid_sat #(
   parameter int IW = 36,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] val,
   input  logic signed [IW-1:0] floor_v,
   input  logic signed [IW-1:0] ceil_v,
   output logic signed [OW-1:0] res
);
   logic signed [IW-1:0] pick;
   always_comb begin
      if (val > ceil_v)       pick = ceil_v;
      else if (val < floor_v) pick = floor_v;
      else                    pick = val;
   end
   assign res = OW'(pick);
endmodule

// File: rtl/fxp_pid.sv
module fxp_pid #(
   parameter int DW   = 16,
   parameter int GW   = 16,
   parameter int FRAC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_stb,
   input  logic                 init_req,
   input  logic signed [DW-1:0] sp,
   input  logic signed [DW-1:0] pv,
   input  logic        [GW-1:0] kp_g,
   input  logic        [GW-1:0] ki_g,
   input  logic        [GW-1:0] kd_g,
   input  logic signed [DW-1:0] lim_hi,
   input  logic signed [DW-1:0] lim_lo,
   output logic signed [DW-1:0] u_out,
   output logic                 u_vld
);
   import pid_pkg::*;

   localparam int EW = DW + 1;
   localparam int PW = EW + GW + 1;
   localparam int AW = DW + FRAC + 1;
   localparam int SW = PW + 2;

   if (FRAC >= GW) begin : g_bad_frac
      $error("fxp_pid: FRAC must be smaller than GW");
   end
   if (DW < 4) begin : g_bad_dw
      $error("fxp_pid: DW must be at least 4");
   end
   if (AW > SW) begin : g_bad_aw
      $error("fxp_pid: accumulator wider than sum path");
   end

   logic                 first_q;
   logic signed [DW-1:0] prev_q;
   logic signed [AW-1:0] acc_q;
   logic signed [DW-1:0] out_q;
   logic                 vld_q;

   logic                 fresh;
   logic signed [EW-1:0] err;
   logic signed [EW-1:0] dpv;
   logic signed [EW-1:0] opnd [N_GAIN];
   logic        [GW-1:0] gsel [N_GAIN];
   logic signed [PW-1:0] prod [N_GAIN];

   assign fresh = init_req | first_q;
   assign err   = EW'(sp) - EW'(pv);
   assign dpv   = fresh ? '0 : (EW'(pv) - EW'(prev_q));

   assign opnd[G_PROP]  = err;
   assign opnd[G_INTEG] = err;
   assign opnd[G_DERIV] = dpv;
   assign gsel[G_PROP]  = kp_g;
   assign gsel[G_INTEG] = ki_g;
   assign gsel[G_DERIV] = kd_g;

   for (genvar g = 0; g < N_GAIN; g++) begin : g_mul
      pid_gmul #(.AW(EW), .GW(GW)) u_mul (
         .opnd(opnd[g]),
         .gain(gsel[g]),
         .prod(prod[g])
      );
   end

   logic signed [SW-1:0] lo_w, hi_w, lo_acc, hi_acc;
   logic signed [SW-1:0] acc_sum, tot, tot_sh;
   logic signed [AW-1:0] acc_base, acc_nx;
   logic signed [DW-1:0] out_nx;

   assign lo_w     = SW'(lim_lo);
   assign hi_w     = SW'(lim_hi);
   assign lo_acc   = lo_w <<< FRAC;
   assign hi_acc   = hi_w <<< FRAC;
   assign acc_base = fresh ? '0 : acc_q;
   assign acc_sum  = SW'(acc_base) + SW'(prod[G_INTEG]);

   pid_sat #(.IW(SW), .OW(AW)) u_acc_sat (
      .val(acc_sum), .floor_v(lo_acc), .ceil_v(hi_acc), .res(acc_nx)
   );

   assign tot    = SW'(prod[G_PROP]) + SW'(acc_nx) - SW'(prod[G_DERIV]);
   assign tot_sh = tot >>> FRAC;

   pid_sat #(.IW(SW), .OW(DW)) u_out_sat (
      .val(tot_sh), .floor_v(lo_w), .ceil_v(hi_w), .res(out_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         prev_q  <= '0;
         acc_q   <= '0;
         out_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= smp_stb;
         if (smp_stb) begin
            first_q <= 1'b0;
            prev_q  <= pv;
            acc_q   <= acc_nx;
            out_q   <= out_nx;
         end
      end
   end

   assign u_out = out_q;
   assign u_vld = vld_q;
endmodule

// File: rtl/fxp_pid_chk.sv
module fxp_pid_chk #(
   parameter int DW   = 16,
   parameter int FRAC = 8,
   localparam int AW  = DW + FRAC + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_stb,
   input logic                 u_vld,
   input logic signed [DW-1:0] u_out,
   input logic signed [DW-1:0] lim_hi,
   input logic signed [DW-1:0] lim_lo,
   input logic signed [AW-1:0] acc_q,
   input logic                 first_q
);
   logic signed [DW-1:0] hi_r, lo_r;
   logic                 seen_r;
   logic                 ok_r;
   logic signed [AW-1:0] hi_b, lo_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_r   <= '0;
         lo_r   <= '0;
         seen_r <= 1'b0;
      end else if (smp_stb) begin
         hi_r   <= lim_hi;
         lo_r   <= lim_lo;
         seen_r <= 1'b1;
      end
   end

   assign ok_r = (lo_r <= hi_r);
   assign hi_b = AW'(hi_r) <<< FRAC;
   assign lo_b = AW'(lo_r) <<< FRAC;

   AST_VLD_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> u_vld); // R10
   AST_VLD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !u_vld); // R10
   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(u_out)); // R10
   AST_OUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (u_vld && ok_r) |-> (u_out >= lo_r && u_out <= hi_r)); // R6
   AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_r && ok_r) |-> (acc_q >= lo_b && acc_q <= hi_b)); // R7
   AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !first_q); // R5
endmodule

bind fxp_pid fxp_pid_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .u_vld(u_vld),
   .u_out(u_out), .lim_hi(lim_hi), .lim_lo(lim_lo),
   .acc_q(acc_q), .first_q(first_q)
);

// File: tb/fxp_pid_test.sv
module fxp_pid_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0, init_req = 1'b0;
   logic signed [15:0] sp = '0, pv = '0, lim_hi = 16'sd1000, lim_lo = -16'sd1000;
   logic [15:0] kp_g = '0, ki_g = '0, kd_g = '0;
   logic signed [15:0] u_out;
   logic u_vld;

   int checks = 0, errors = 0;
   longint m_acc, m_prev;
   bit m_first;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fxp_pid uut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .init_req(init_req),
      .sp(sp), .pv(pv), .kp_g(kp_g), .ki_g(ki_g), .kd_g(kd_g),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .u_out(u_out), .u_vld(u_vld)
   );

   function automatic longint clampl(longint x, longint lo, longint hi);
      if (x > hi) return hi;
      if (x < lo) return lo;
      return x;
   endfunction

   function automatic longint model(longint s, longint p, bit ini);
      longint e, d, tot;
      longint lo = lim_lo, hi = lim_hi;
      e = s - p;
      if (ini || m_first) begin m_acc = 0; d = 0; end
      else d = p - m_prev;
      m_acc = clampl(m_acc + longint'(ki_g) * e, lo * 256, hi * 256);
      tot = longint'(kp_g) * e + m_acc - longint'(kd_g) * d;
      m_prev = p;
      m_first = 1'b0;
      return clampl(tot >>> 8, lo, hi);
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic smp(longint s, longint p, bit ini, string req);
      longint exp;
      @(negedge clk);
      sp = 16'(s); pv = 16'(p); init_req = ini; smp_stb = 1'b1;
      exp = model(longint'(sp), longint'(pv), ini);
      @(negedge clk);
      smp_stb = 1'b0; init_req = 1'b0;
      check(u_vld == 1'b1, {req, "/R10 valid"}, u_vld, 1);
      check(longint'(u_out) == exp, req, u_out, exp);
   endtask

   task automatic set_g(int p, int i, int d);
      kp_g = 16'(p); ki_g = 16'(i); kd_g = 16'(d);
   endtask

   initial begin
      #(5.0 * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      longint hold;
      m_first = 1'b1; m_acc = 0; m_prev = 0;
      repeat (3) @(negedge clk);
      check(u_out == 0, "R11 reset out", u_out, 0);
      check(u_vld == 0, "R11 reset vld", u_vld, 0);
      rst_n = 1'b1;

      // R5: first sample after reset has no derivative kick
      set_g(0, 0, 256);
      smp(0, 100, 0, "R5 first sample");
      check(u_out == 0, "R5 no kick", u_out, 0);
      smp(0, 100, 0, "R5 steady");
      smp(0, 110, 0, "R3 dpv");
      check(u_out == -10, "R3 dpv value", u_out, -10);

      // R3: setpoint step, steady pv, derivative only
      smp(500, 110, 0, "R3 setpoint step");
      check(u_out == 0, "R3 no setpoint kick", u_out, 0);

      // R10: held and no valid between strobes
      hold = u_out;
      repeat (3) @(negedge clk);
      check(u_vld == 0, "R10 valid low", u_vld, 0);
      check(longint'(u_out) == hold, "R10 held", u_out, hold);

      // R9: floor rounding
      set_g(128, 0, 0);
      smp(0, 1, 1, "R9 -0.5 floors");
      check(u_out == -1, "R9 -1", u_out, -1);
      smp(1, 0, 1, "R9 +0.5 floors");
      check(u_out == 0, "R9 0", u_out, 0);

      // R1/R2: proportional sweep over gains and errors
      for (int gk = 0; gk < 1024; gk += 37) begin
         set_g(gk, 0, 0);
         for (int e = -20; e <= 20; e += 3) smp(e, 0, 1, "R1 P sweep");
      end

      // R2: extreme error, full gains, wide limits
      lim_hi = 16'sd32767; lim_lo = -16'sd32768;
      set_g(16'hFFFF, 16'hFFFF, 16'hFFFF);
      smp(32767, -32768, 1, "R2 extreme pos");
      smp(-32768, 32767, 0, "R2 extreme neg");
      smp(-32768, 32767, 0, "R6 extreme clamp");

      // R7: long saturation, then error reversal
      lim_hi = 16'sd200; lim_lo = -16'sd200;
      set_g(0, 256, 0);
      smp(100, 0, 1, "R7 wind");
      for (int k = 0; k < 40; k++) smp(100, 0, 0, "R7 wind");
      check(u_out == 200, "R7 at limit", u_out, 200);
      smp(-50, 0, 0, "R7 recover");
      check(u_out == 150, "R7 prompt recovery", u_out, 150);

      // R8: bumpless gain change at zero error
      set_g(300, 200, 100);
      smp(30, 0, 1, "R8 build");
      smp(30, 0, 0, "R8 build");
      smp(0, 0, 0, "R8 settle");
      smp(0, 0, 0, "R8 settle");
      hold = u_out;
      set_g(900, 17, 4000);
      smp(0, 0, 0, "R8 gain change");
      check(longint'(u_out) == hold, "R8 no bump", u_out, hold);

      // R4: initialize clears integral and derivative
      set_g(0, 256, 256);
      smp(50, 0, 0, "R4 pre");
      smp(0, 70, 1, "R4 init");
      check(u_out == -70, "R4 cleared", u_out, -70);

      // R1/R6/R7: mixed sweep with random inputs, gains and limits
      for (int n = 0; n < 3000; n++) begin
         int a, b;
         if (n % 50 == 0) begin
            a = int'($urandom_range(2000)) - 1000;
            b = int'($urandom_range(2000)) - 1000;
            lim_lo = 16'((a < b) ? a : b);
            lim_hi = 16'((a < b) ? b : a);
            set_g(int'($urandom_range(1200)), int'($urandom_range(600)),
                  int'($urandom_range(800)));
         end
         smp(int'($urandom_range(4000)) - 2000, int'($urandom_range(4000)) - 2000,
             ($urandom_range(40) == 0), "R1 mixed");
         check(u_out >= lim_lo && u_out <= lim_hi, "R6 in range", u_out, lim_hi);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule